// File: doc/BRIEF.md
# Platform Status and Control Register Block

This block is the register file of a board-level system controller. It answers a plain 32-bit register bus: an address, separate read and write strobes, an access size in bytes, write data and registered read data. Most of its words are constants that tell boot software how the board was built: memory lock and calibration state, enabled PCIe links and the changelist identifiers. Two words are assembled from live inputs. These are the reference clock frequency in MHz and the installed memory size in GiB.

Software restarts the whole system by writing a command word with one bit set. The block turns that write into a one-cycle reset request for the system reset logic. Any access that is not a full 32-bit word is ignored, and a narrow read returns zero. A full-word access to an offset that holds no register pulses a debug flag.

Top module: `plat_ctrl_regs`

## Requirements
- R1: While `rstN` is low and after it rises, `busRdata`, `sysRstReq` and `unmappedHit` are 0 until a bus access changes them.
- R2: Only address bits 15:0 select a register; bits 31:16 have no effect on reads or writes.
- R3: The word reads of offsets 0x00, 0x04, 0x08 (identifier and changelists), 0x10 (reset command) and 0x18 (link status) return 0x00000000.
- R4: The word read of offset 0x14 (memory status) returns 0x00000005: bit 0 is locked and bit 2 is calibrated.
- R5: The word read of offset 0x30 (clock divider) returns 1 in bits 7:0, `refMhz` in bits 15:8, 1 in bits 23:16 and 1 in bits 31:24.
- R6: The word read of offset 0x34 (build configuration) returns 0x0000000E: bits 1, 2 and 3 are the three enabled PCIe links and bit 0 is clear.
- R7: The word read of offset 0x38 (memory configuration) returns `memGib` in bits 3:0 and ones in bits 15:4, with the upper bits zero.
- R8: A word write to offset 0x10 with bit 4 set drives `sysRstReq` high for exactly the one cycle after the write.
- R9: A word write to offset 0x10 with bit 4 clear raises no reset request, whatever the other bits hold.
- R10: `busSize` gives the access size in bytes, and 4 means a full word. Any other size is ignored: such a read loads 0 into `busRdata`, and such a write raises neither `sysRstReq` nor `unmappedHit`.
- R11: Writes to the read-only offsets 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 are discarded, and later reads return the same values.
- R12: A full-word read or write of any other offset reads 0, changes nothing, and pulses `unmappedHit` in the following cycle.
- R13: `busRdata` is loaded on the clock edge that samples `busRd` and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 32 | Byte address of the access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busSize | input | 4 | Access size in bytes (4 = full word) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| refMhz | input | 8 | Reference clock frequency in MHz |
| memGib | input | 4 | Installed memory size in GiB |
| sysRstReq | output | 1 | One-cycle system reset request |
| unmappedHit | output | 1 | Pulses after a word access to an unmapped offset |

## Verification
The assertions assume that `busRd` and `busWr` never rise in the same cycle and that each strobe lasts one cycle per access. They also assume that `refMhz` and `memGib` stay constant while a read of the words built from them is in flight. The bench drives every access at a falling edge, holds it for exactly one clock, and then drops both strobes. It changes the live inputs only during idle cycles, so the stimulus always stays within these assumptions.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;

  localparam int unsigned DEC_W       = 16;
  localparam int unsigned RST_CMD_BIT = 4;

  localparam logic [DEC_W-1:0] OFF_BUILD_ID  = 16'h0000;
  localparam logic [DEC_W-1:0] OFF_CORE_CL   = 16'h0004;
  localparam logic [DEC_W-1:0] OFF_WRAP_CL   = 16'h0008;
  localparam logic [DEC_W-1:0] OFF_RST_CMD   = 16'h0010;
  localparam logic [DEC_W-1:0] OFF_MEM_STAT  = 16'h0014;
  localparam logic [DEC_W-1:0] OFF_LINK_STAT = 16'h0018;
  localparam logic [DEC_W-1:0] OFF_CLK_DIV   = 16'h0030;
  localparam logic [DEC_W-1:0] OFF_BUILD_CFG = 16'h0034;
  localparam logic [DEC_W-1:0] OFF_MEM_CFG   = 16'h0038;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_MEM_STAT,
    SEL_CLK_DIV,
    SEL_BUILD_CFG,
    SEL_MEM_CFG
  } regSel_e;

  typedef struct packed {
    logic    rdLoad;
    regSel_e rdSel;
    logic    rstFire;
    logic    missPulse;
  } strobe_t;

endpackage

// File: rtl/plat_regs_ctrl.sv
module plat_regs_ctrl
  import plat_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [SIZE_W-1:0] busSize,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strobes
);

  localparam logic [SIZE_W-1:0] WORD_BYTES = SIZE_W'(DATA_W / 8);

  logic [DEC_W-1:0] offset;
  logic             fullWord;
  logic             mapped;
  regSel_e          decSel;
  logic             unusedIn;

  assign offset   = busAddr[DEC_W-1:0];
  assign fullWord = (busSize == WORD_BYTES);
  assign unusedIn = ^{busAddr[ADDR_W-1:DEC_W], busWdata};

  always_comb begin
    mapped = 1'b1;
    decSel = SEL_ZERO;
    case (offset)
      OFF_BUILD_ID, OFF_CORE_CL, OFF_WRAP_CL,
      OFF_RST_CMD, OFF_LINK_STAT: decSel = SEL_ZERO;
      OFF_MEM_STAT:  decSel = SEL_MEM_STAT;
      OFF_CLK_DIV:   decSel = SEL_CLK_DIV;
      OFF_BUILD_CFG: decSel = SEL_BUILD_CFG;
      OFF_MEM_CFG:   decSel = SEL_MEM_CFG;
      default:       mapped = 1'b0;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.rdLoad    = busRd;
    strobes.rdSel     = (busRd && fullWord) ? decSel : SEL_ZERO;
    strobes.rstFire   = busWr && fullWord && (offset == OFF_RST_CMD)
                        && busWdata[RST_CMD_BIT];
    strobes.missPulse = (busRd || busWr) && fullWord && !mapped;
  end

  // R10: a narrow access never produces a side-effect strobe
  a_r10_narrow_silent: assert property (@(posedge clk) disable iff (!rstN)
    (busSize != WORD_BYTES) |-> (!strobes.rstFire && !strobes.missPulse));

endmodule

// File: rtl/plat_regs_data.sv
module plat_regs_data
  import plat_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REF_W  = 8,
  parameter int unsigned MEM_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [REF_W-1:0]  refMhz,
  input  logic [MEM_W-1:0]  memGib,
  output logic [DATA_W-1:0] busRdata,
  output logic              sysRstReq,
  output logic              unmappedHit
);

  localparam int unsigned FLD_W    = 8;
  localparam int unsigned FREQ_LSB = 4;
  localparam int unsigned FREQ_W   = 12;

  logic [DATA_W-1:0] rdWord;

  always_comb begin
    rdWord = '0;
    case (strobes.rdSel)
      SEL_MEM_STAT: begin
        rdWord[0] = 1'b1;
        rdWord[2] = 1'b1;
      end
      SEL_CLK_DIV: begin
        rdWord[0*FLD_W +: FLD_W] = FLD_W'(1);
        rdWord[1*FLD_W +: REF_W] = refMhz;
        rdWord[2*FLD_W +: FLD_W] = FLD_W'(1);
        rdWord[3*FLD_W +: FLD_W] = FLD_W'(1);
      end
      SEL_BUILD_CFG: rdWord[3:1] = 3'b111;
      SEL_MEM_CFG: begin
        rdWord[MEM_W-1:0]               = memGib;
        rdWord[FREQ_LSB +: FREQ_W]      = '1;
      end
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata    <= '0;
      sysRstReq   <= 1'b0;
      unmappedHit <= 1'b0;
    end else begin
      if (strobes.rdLoad) busRdata <= rdWord;
      sysRstReq   <= strobes.rstFire;
      unmappedHit <= strobes.missPulse;
    end
  end

  // R13: read data holds when no read is sampled
  a_r13_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdLoad |=> $stable(busRdata));

endmodule

// File: rtl/plat_ctrl_regs.sv
module plat_ctrl_regs
  import plat_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SIZE_W = 4,
  parameter int unsigned REF_W  = 8,
  parameter int unsigned MEM_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [SIZE_W-1:0] busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [REF_W-1:0]  refMhz,
  input  logic [MEM_W-1:0]  memGib,
  output logic              sysRstReq,
  output logic              unmappedHit
);

  strobe_t strobes;

  plat_regs_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busSize(busSize), .busWdata(busWdata),
    .strobes(strobes)
  );

  plat_regs_data #(
    .DATA_W(DATA_W), .REF_W(REF_W), .MEM_W(MEM_W)
  ) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .refMhz(refMhz),
    .memGib(memGib), .busRdata(busRdata), .sysRstReq(sysRstReq),
    .unmappedHit(unmappedHit)
  );

  // R8: a reset request only follows a word write of the command bit
  a_r8_cause: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> $past(busWr && (busSize == SIZE_W'(4))
                        && (busAddr[DEC_W-1:0] == OFF_RST_CMD)
                        && busWdata[RST_CMD_BIT]));

  // R10: a narrow read returns zero
  a_r10_narrow_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (busSize != SIZE_W'(4))) |=> (busRdata == '0));

  // R12: the debug flag only follows a bus access
  a_r12_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    unmappedHit |-> $past(busRd || busWr));

endmodule

// File: tb/test_plat_ctrl_regs.sv
module test_plat_ctrl_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busSize = 4'd4;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  refMhz = 8'd50;
  logic [3:0]  memGib = 4'd2;
  logic        sysRstReq;
  logic        unmappedHit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  plat_ctrl_regs i_plat_ctrl_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .refMhz(refMhz), .memGib(memGib),
    .sysRstReq(sysRstReq), .unmappedHit(unmappedHit)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  size;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] expData;
    logic        expRst;
    logic        expFlag;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 4'd4, 32'h0000_0000, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8'd3},  // R3
    '{1'b0, 4'd4, 32'h0000_0004, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8'd3},  // R3
    '{1'b0, 4'd4, 32'h0000_0008, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8'd3},  // R3
    '{1'b0, 4'd4, 32'h0000_0014, 32'h0, 32'h0000_0005, 1'b0, 1'b0, 8'd4},  // R4
    '{1'b0, 4'd4, 32'h0000_0030, 32'h0, 32'h0101_3201, 1'b0, 1'b0, 8'd5},  // R5
    '{1'b0, 4'd4, 32'h0000_0034, 32'h0, 32'h0000_000E, 1'b0, 1'b0, 8'd6},  // R6
    '{1'b0, 4'd4, 32'h0000_0038, 32'h0, 32'h0000_FFF2, 1'b0, 1'b0, 8'd7},  // R7
    '{1'b0, 4'd4, 32'hABCD_0014, 32'h0, 32'h0000_0005, 1'b0, 1'b0, 8'd2},  // R2
    '{1'b0, 4'd4, 32'h0000_0018, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8'd3},  // R3
    '{1'b0, 4'd4, 32'h0000_0034, 32'h0, 32'h0000_000E, 1'b0, 1'b0, 8'd6},  // R6
    '{1'b0, 4'd2, 32'h0000_0034, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 8'd10}, // R10
    '{1'b0, 4'd4, 32'h0000_001C, 32'h0, 32'h0000_0000, 1'b0, 1'b1, 8'd12}, // R12
    '{1'b1, 4'd4, 32'h0000_0014, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0, 8'd11}, // R11
    '{1'b0, 4'd4, 32'h0000_0014, 32'h0, 32'h0000_0005, 1'b0, 1'b0, 8'd11}, // R11
    '{1'b1, 4'd4, 32'h0000_0010, 32'hFFFF_FFEF, 32'h0, 1'b0, 1'b0, 8'd9},  // R9
    '{1'b1, 4'd1, 32'h0000_0010, 32'h0000_0010, 32'h0, 1'b0, 1'b0, 8'd10}, // R10
    '{1'b1, 4'd4, 32'h0000_0040, 32'h0000_0010, 32'h0, 1'b0, 1'b1, 8'd12}, // R12
    '{1'b1, 4'd4, 32'h0000_0010, 32'h0000_0010, 32'h0, 1'b1, 1'b0, 8'd8}   // R8
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] size,
                        input logic [31:0] addr, input logic [31:0] wdata);
    busAddr  = addr;
    busSize  = size;
    busWdata = wdata;
    busRd    = !wr;
    busWr    = wr;
    @(negedge clk);
    busRd = 1'b0;
    busWr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "rdata in reset", busRdata, 32'h0);
    check("R1", "rst req in reset", {31'h0, sysRstReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "flag after reset", {31'h0, unmappedHit}, 32'h0);
    check("R1", "rdata after reset", busRdata, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d", TBL[i].req);
      access(TBL[i].wr, TBL[i].size, TBL[i].addr, TBL[i].wdata);
      if (!TBL[i].wr) check(tag, $sformatf("vec %0d rdata", i), busRdata, TBL[i].expData);
      check(tag, $sformatf("vec %0d rst req", i), {31'h0, sysRstReq}, {31'h0, TBL[i].expRst});
      check(tag, $sformatf("vec %0d flag", i), {31'h0, unmappedHit}, {31'h0, TBL[i].expFlag});
    end

    // R8: the pulse lasts a single cycle
    @(negedge clk);
    check("R8", "pulse width", {31'h0, sysRstReq}, 32'h0);

    // R13: read data holds across idle cycles and a live-input change
    access(1'b0, 4'd4, 32'h0000_0030, 32'h0);
    check("R5", "clock divider", busRdata, 32'h0101_3201);
    refMhz = 8'd100;
    memGib = 4'd1;
    repeat (3) @(negedge clk);
    check("R13", "hold without read", busRdata, 32'h0101_3201);
    access(1'b0, 4'd4, 32'h0000_0030, 32'h0);
    check("R5", "clock divider new ref", busRdata, 32'h0101_6401);
    access(1'b0, 4'd4, 32'h0000_0038, 32'h0);
    check("R7", "memory config new size", busRdata, 32'h0000_FFF1);

    // R1: reset in mid-run clears the outputs
    access(1'b1, 4'd4, 32'h0000_0010, 32'h0000_0010);
    check("R8", "second request", {31'h0, sysRstReq}, 32'h1);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "rdata cleared", busRdata, 32'h0);
    check("R1", "rst req cleared", {31'h0, sysRstReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule